// File: doc/BRIEF.md
# Decimal-Capable 8-bit ALU

This block is the purely combinational arithmetic and logic stage of a small 8-bit processor datapath. In one pass it produces a result, a carry out and a signed overflow flag from two operands, a carry in, a decimal-mode select and a four-bit operation code. The operation set covers binary and decimal add and subtract, the three bitwise logic functions, a one-place right shift, single-bit clear, set and test selected by an index in the second operand, and a bitwise inverse.

Decimal arithmetic works digit by digit. Each four-bit digit of the sum or difference is adjusted by six whenever it leaves the decimal range, and the carry between digits follows the decimal rule. A separate bus output repeats the result while the drive enable is high and reads zero otherwise, so several sources can be OR-combined onto a shared bus. The width is a parameter and must be a multiple of four. It defaults to 8.

Top module: `decimal_alu`

## Requirements
- R1: Code 0 gives result = (A + B + carry_in) mod 2^W and carry_out = the binary carry from the top bit, for either value of decimal_in.
- R2: Code 1 gives result = (A + ~B + carry_in) mod 2^W and carry_out = the top-bit carry of that sum, so carry_in = 1 means no borrow in and carry_out = 1 means no borrow out. decimal_in has no effect.
- R3: For codes 0 to 3, ovf_out = 1 exactly when A and the effective B (B for add, ~B for subtract) have the same sign bit and the binary sum A + effective B + carry_in has a different sign bit. This holds even in decimal mode. For every other code, ovf_out = 0.
- R4: With decimal_in low, codes 2 and 3 give the same result and carry_out as codes 0 and 1.
- R5: Code 2 with decimal_in high adds digit by digit from the low digit. For each digit, t = a + b + c, with c starting at carry_in. If t > 9, the digit is (t + 6) mod 16 and the next c is 1. Otherwise the digit is t and the next c is 0. carry_out is the final c.
- R6: Code 3 with decimal_in high subtracts digit by digit from the low digit. For each digit, d = a - b - borrow, with borrow starting at 1 - carry_in. If d < 0, the digit is (d + 10) mod 16 and the next borrow is 1. Otherwise the digit is d and the next borrow is 0. carry_out is 1 - final borrow.
- R7: Codes 4, 5 and 6 give A AND B, A OR B and A XOR B, each with carry_out = carry_in.
- R8: Code 7 gives A shifted right by one place, with a zero in the top bit and carry_out = bit 0 of A.
- R9: Codes 8, 9 and 10 take the bit index k from the low log2(W) bits of B and ignore the upper bits of B. Code 8 gives A with bit k cleared. Code 9 gives A with bit k set. Code 10 gives A AND (1 << k). In all three, carry_out = carry_in.
- R10: Code 11 gives ~A with carry_out = carry_in.
- R11: Codes 12 to 15 give a zero result with carry_out = carry_in.
- R12: bus_out equals result_out while drive_en is high and is all zeros while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand, also the bit index for codes 8-10 |
| carry_in | input | 1 | Carry in (1 = no borrow for subtract) |
| decimal_in | input | 1 | Decimal mode select for codes 2 and 3 |
| op_in | input | 4 | Operation code |
| drive_en | input | 1 | Enables the bus output |
| result_out | output | WIDTH | Result |
| carry_out | output | 1 | Carry out |
| ovf_out | output | 1 | Signed overflow |
| bus_out | output | WIDTH | Result while drive_en is high, zero otherwise |

## Verification
The bench builds the block with its default WIDTH of 8. That gives two decimal digits, so a carry or borrow passes between the digits and also leaves the top digit. The bit index is three bits wide, so values of B above 7 test that the upper bits are ignored. Because 8-bit operands are small, random draws regularly land on valid digits, on invalid digits (10-15), on signed-overflow boundaries and on every opcode, including the unused codes. Directed cases add the wrap-arounds 99+1 and 00-1 in decimal and 7F+1 and 80-1 in binary.

// File: rtl/dalu_pkg.sv
package dalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDD = 4'd2,
    OP_SUBD = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_SHR  = 4'd7,
    OP_BCLR = 4'd8,
    OP_BSET = 4'd9,
    OP_BTST = 4'd10,
    OP_INV  = 4'd11
  } alu_op_e;

  // One digit step. b_eff is already inverted for subtraction.
  // Returns {carry_out, digit}.
  function automatic logic [4:0] digit_step(input logic [3:0] a_d,
                                            input logic [3:0] b_eff,
                                            input logic       c_in,
                                            input logic       dec,
                                            input logic       sub);
    logic [4:0] t;
    logic       c;
    logic [3:0] d;
    t = {1'b0, a_d} + {1'b0, b_eff} + {4'b0, c_in};
    if (!dec) begin
      c = t[4];
      d = t[3:0];
    end else if (!sub) begin
      c = (t > 5'd9);
      d = c ? (t[3:0] + 4'd6) : t[3:0];
    end else begin
      c = t[4];
      d = c ? t[3:0] : (t[3:0] - 4'd6);
    end
    return {c, d};
  endfunction

  // Signed overflow from the sign bits of the two addends and the sum.
  function automatic logic signed_ovf(input logic sa, input logic sb,
                                      input logic sy);
    return (sa == sb) && (sy != sa);
  endfunction

  function automatic logic digit_is_decimal(input logic [3:0] d);
    return d <= 4'd9;
  endfunction

endpackage

// File: rtl/dalu_digit_cell.sv
module dalu_digit_cell
  import dalu_pkg::*;
(
  input  logic [3:0] a_d,
  input  logic [3:0] b_d,
  input  logic       c_in,
  input  logic       dec,
  input  logic       sub,
  output logic [3:0] y_d,
  output logic       c_out
);
  logic [4:0] step;

  always_comb begin
    step  = digit_step(a_d, b_d, c_in, dec, sub);
    y_d   = step[3:0];
    c_out = step[4];
  end
endmodule

// File: rtl/dalu_addsub.sv
module dalu_addsub
  import dalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             sub,
  input  logic             dec,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int NIBBLES = WIDTH / 4;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   bin_full;      // plain binary adder
  logic [WIDTH-1:0] chain_sum;     // digit chain result
  logic [NIBBLES:0] chain_c;
  logic [NIBBLES-1:0] in_dec_ok;
  logic [NIBBLES-1:0] out_dec_ok;

  assign b_eff    = sub ? ~b : b;
  assign bin_full = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
  assign chain_c[0] = cin;

  for (genvar n = 0; n < NIBBLES; n++) begin : g_digit
    dalu_digit_cell u_cell (
      .a_d   (a[4*n +: 4]),
      .b_d   (b_eff[4*n +: 4]),
      .c_in  (chain_c[n]),
      .dec   (dec),
      .sub   (sub),
      .y_d   (chain_sum[4*n +: 4]),
      .c_out (chain_c[n+1])
    );
    assign in_dec_ok[n]  = digit_is_decimal(a[4*n +: 4]) &&
                           digit_is_decimal(b[4*n +: 4]);
    assign out_dec_ok[n] = digit_is_decimal(chain_sum[4*n +: 4]);
  end

  assign sum  = dec ? chain_sum : bin_full[WIDTH-1:0];
  assign cout = dec ? chain_c[NIBBLES] : bin_full[WIDTH];
  assign ovf  = signed_ovf(a[WIDTH-1], b_eff[WIDTH-1], bin_full[WIDTH-1]);

  // R4: in binary mode the digit chain and the flat adder must agree
  always_comb begin
    if (!dec) begin
      assert_chain_matches_binary_R4: assert ({chain_c[NIBBLES], chain_sum} == bin_full)
        else $error("digit chain differs from binary adder");
    end
  end

  // R5/R6: valid decimal inputs must give valid decimal digits
  always_comb begin
    if (dec && (&in_dec_ok)) begin
      assert_decimal_digits_R5: assert (&out_dec_ok)
        else $error("decimal result digit out of range");
    end
  end
endmodule

// File: rtl/dalu_logic_unit.sv
module dalu_logic_unit
  import dalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             cout
);
  localparam int IDX_W = $clog2(WIDTH);

  logic [IDX_W-1:0] bit_idx;
  logic [WIDTH-1:0] bit_mask;

  assign bit_idx  = b[IDX_W-1:0];
  assign bit_mask = {{(WIDTH-1){1'b0}}, 1'b1} << bit_idx;

  always_comb begin
    cout = cin;
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHR:  begin
        y    = {1'b0, a[WIDTH-1:1]};
        cout = a[0];
      end
      OP_BCLR: y = a & ~bit_mask;
      OP_BSET: y = a | bit_mask;
      OP_BTST: y = a & bit_mask;
      OP_INV:  y = ~a;
      default: y = '0;
    endcase
  end

  // R8: a right shift always empties the top bit
  always_comb begin
    if (op == OP_SHR) begin
      assert_shift_top_clear_R8: assert (y[WIDTH-1] == 1'b0)
        else $error("shift left the top bit set");
    end
  end

  // R9: set leaves the indexed bit high, clear leaves it low
  always_comb begin
    if (op == OP_BSET) begin
      assert_bit_set_R9: assert (y[bit_idx] == 1'b1)
        else $error("indexed bit not set");
    end
    if (op == OP_BCLR) begin
      assert_bit_clear_R9: assert (y[bit_idx] == 1'b0)
        else $error("indexed bit not cleared");
    end
  end
endmodule

// File: rtl/decimal_alu.sv
module decimal_alu
  import dalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  input  logic             decimal_in,
  input  logic [3:0]       op_in,
  input  logic             drive_en,
  output logic [WIDTH-1:0] result_out,
  output logic             carry_out,
  output logic             ovf_out,
  output logic [WIDTH-1:0] bus_out
);
  logic             is_arith;
  logic             arith_sub;
  logic             arith_dec;
  logic [WIDTH-1:0] arith_y;
  logic             arith_c;
  logic             arith_v;
  logic [WIDTH-1:0] logic_y;
  logic             logic_c;

  assign is_arith  = (op_in[3:2] == 2'b00);
  assign arith_sub = op_in[0];
  assign arith_dec = op_in[1] & decimal_in;

  dalu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a    (a_in),
    .b    (b_in),
    .cin  (carry_in),
    .sub  (arith_sub),
    .dec  (arith_dec),
    .sum  (arith_y),
    .cout (arith_c),
    .ovf  (arith_v)
  );

  dalu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op   (op_in),
    .a    (a_in),
    .b    (b_in),
    .cin  (carry_in),
    .y    (logic_y),
    .cout (logic_c)
  );

  assign result_out = is_arith ? arith_y : logic_y;
  assign carry_out  = is_arith ? arith_c : logic_c;
  assign ovf_out    = is_arith & arith_v;
  assign bus_out    = drive_en ? result_out : '0;

  // R3: no overflow outside the add/subtract codes
  always_comb begin
    if (op_in[3:2] != 2'b00) begin
      assert_no_overflow_R3: assert (ovf_out == 1'b0)
        else $error("overflow raised by non-arithmetic code");
    end
  end

  // R11: unused codes give zero and pass the carry through
  always_comb begin
    if (op_in[3:2] == 2'b11) begin
      assert_unused_zero_R11: assert (result_out == '0 && carry_out == carry_in)
        else $error("unused code produced a value");
    end
  end

  // R12: bus follows the result only while enabled
  always_comb begin
    assert_bus_gate_R12: assert (bus_out == (drive_en ? result_out : '0))
      else $error("bus output not gated by enable");
  end
endmodule

// File: tb/decimal_alu_tb_top.sv
module decimal_alu_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         carry_in = 1'b0, decimal_in = 1'b0, drive_en = 1'b0;
  logic [3:0]   op_in = 4'd0;
  logic [W-1:0] result_out, bus_out;
  logic         carry_out, ovf_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  decimal_alu #(.WIDTH(W)) dut_i (
    .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .decimal_in(decimal_in),
    .op_in(op_in), .drive_en(drive_en), .result_out(result_out),
    .carry_out(carry_out), .ovf_out(ovf_out), .bus_out(bus_out)
  );

  task automatic check(input string tag, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h (op=%0d a=%0h b=%0h ci=%0d dec=%0d)",
               tag, what, actual, expected, op_in, a_in, b_in, carry_in, decimal_in);
    end
  endtask

  // Reference model written from the requirement text.
  task automatic model(input int op, input int a, input int b, input int ci,
                       input int dc, output int y, output int co, output int v,
                       output string tag);
    int bb, s, c, br, an, bn, t, d;
    y = 0; co = ci; v = 0;
    if (op <= 3) begin
      bb = (op % 2 == 1) ? (~b & 8'hFF) : b;
      s  = a + bb + ci;
      v  = (((a >> 7) & 1) == ((bb >> 7) & 1)) && (((s >> 7) & 1) != ((a >> 7) & 1));
      if (op >= 2 && dc != 0 && op == 2) begin
        tag = "R5"; c = ci;
        for (int i = 0; i < 2; i++) begin
          an = (a >> (4*i)) & 15; bn = (b >> (4*i)) & 15;
          t = an + bn + c;
          if (t >= 10) begin d = (t - 10) & 15; c = 1; end
          else begin d = t; c = 0; end
          y = y | (d << (4*i));
        end
        co = c;
      end else if (op == 3 && dc != 0) begin
        tag = "R6"; br = 1 - ci;
        for (int i = 0; i < 2; i++) begin
          an = (a >> (4*i)) & 15; bn = (b >> (4*i)) & 15;
          d = an - bn - br;
          if (d < 0) begin d = (d + 10) & 15; br = 1; end
          else br = 0;
          y = y | (d << (4*i));
        end
        co = 1 - br;
      end else begin
        tag = (op == 0) ? "R1" : (op == 1) ? "R2" : "R4";
        y  = s & 8'hFF;
        co = (s >> 8) & 1;
      end
    end else begin
      case (op)
        4: begin y = a & b; tag = "R7"; end
        5: begin y = a | b; tag = "R7"; end
        6: begin y = a ^ b; tag = "R7"; end
        7: begin y = a / 2; co = a % 2; tag = "R8"; end
        8: begin y = a & ~(1 << (b % 8)) & 8'hFF; tag = "R9"; end
        9: begin y = a | (1 << (b % 8)); tag = "R9"; end
        10: begin y = a & (1 << (b % 8)); tag = "R9"; end
        11: begin y = ~a & 8'hFF; tag = "R10"; end
        default: begin y = 0; tag = "R11"; end
      endcase
    end
  endtask

  task automatic apply(input int op, input int a, input int b, input int ci,
                       input int dc, input int oe);
    int ey, ec, ev;
    string tag;
    @(negedge clk);
    op_in = op[3:0]; a_in = a[7:0]; b_in = b[7:0];
    carry_in = ci[0]; decimal_in = dc[0]; drive_en = oe[0];
    #1;
    model(op, a, b, ci, dc, ey, ec, ev, tag);
    check(tag, "result", int'(result_out), ey);
    check(tag, "carry", int'(carry_out), ec);
    check("R3", "ovf", int'(ovf_out), ev);
    check("R12", "bus", int'(bus_out), (oe != 0) ? ey : 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0C0D);
    repeat (3) @(posedge clk);
    #1;
    // reset state: all-zero inputs give a zero add
    check("R1", "reset result", int'(result_out), 0);
    check("R3", "reset ovf", int'(ovf_out), 0);
    check("R12", "reset bus", int'(bus_out), 0);
    rst_n = 1'b1;

    // directed corners
    apply(2, 8'h99, 8'h01, 0, 1, 1);  // R5 99+1 -> 00 carry
    apply(2, 8'h58, 8'h46, 1, 1, 1);  // R5 -> 05 carry
    apply(2, 8'h09, 8'h01, 0, 1, 1);  // R5 low digit carry
    apply(3, 8'h00, 8'h01, 1, 1, 1);  // R6 00-1 -> 99 borrow
    apply(3, 8'h50, 8'h25, 1, 1, 1);  // R6 no borrow
    apply(3, 8'h10, 8'h01, 0, 1, 1);  // R6 borrow in
    apply(0, 8'h7F, 8'h01, 0, 1, 1);  // R1/R3 overflow, dec ignored
    apply(1, 8'h80, 8'h01, 1, 1, 1);  // R2/R3 overflow, dec ignored
    apply(1, 8'h05, 8'h05, 1, 0, 1);  // R2 equal -> 0 no borrow
    apply(2, 8'h99, 8'h99, 1, 0, 1);  // R4 binary under code 2
    apply(3, 8'h12, 8'h34, 1, 0, 1);  // R4 binary under code 3
    apply(7, 8'h81, 8'h00, 0, 0, 1);  // R8 shift out a one
    apply(9, 8'h00, 8'hF9, 0, 0, 1);  // R9 upper index bits ignored
    apply(8, 8'hFF, 8'h0F, 1, 0, 1);  // R9 clear bit 7
    apply(10, 8'hA5, 8'h22, 1, 0, 1); // R9 test bit 2
    apply(11, 8'h3C, 8'h00, 1, 0, 1); // R10
    for (int op = 12; op < 16; op++) apply(op, 8'hFF, 8'hFF, 1, 1, 1); // R11
    apply(5, 8'hF0, 8'h0F, 0, 0, 0);  // R12 bus idle with enable low
    apply(6, 8'hAA, 8'hFF, 1, 0, 1);  // R7

    // constrained random: decimal-leaning operands half the time
    for (int i = 0; i < 4000; i++) begin
      int op, a, b;
      op = $urandom_range(15);
      if ($urandom_range(1) == 1) begin
        a = $urandom_range(9) * 16 + $urandom_range(9);
        b = $urandom_range(9) * 16 + $urandom_range(9);
      end else begin
        a = $urandom_range(255);
        b = $urandom_range(255);
      end
      apply(op, a, b, $urandom_range(1), $urandom_range(1), $urandom_range(1));
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule